// File: doc/BRIEF.md
# Display Address Stepper with DRAM Refresh Output

This block produces the graphic display refresh address for a frame-buffer controller. A start address is loaded, and after that each display-cycle strobe moves the address forward by an amount set by a 3-bit step-mode code. Five modes add a fixed power-of-two number of words. One mode holds the address. One mode adds a single word on every second display cycle.

While horizontal sync is low, the block places the value of an 8-bit DRAM refresh counter on the multiplexed frame-buffer bus instead of the address. Each frame-buffer access counts it down by one. The bit position of the counter on the bus follows the step mode, so the refresh rows line up with the address bits that the step mode moves. Every bus bit and upper address bit outside the counter field is driven low. Until software sets the start bit, the block holds its sync output low, so the bus carries refresh addresses and the display address stays still.

Top module: `gai_refresh_unit`

## Requirements
- R1: After reset, the display address is 0, the refresh counter is 0, the half-rate phase is clear and the sync output is low.
- R2: With the start bit set, a display strobe in mode 000, 001, 010, 011 or 100 adds 1, 2, 4, 8 or 16 words to the address, wrapping modulo 2^20.
- R3: In mode 101 a display strobe leaves the address unchanged.
- R4: In modes 110 and 111 the address advances by one word on every second display strobe. The first strobe after a start-address load does not advance it.
- R5: A start-address load sets the address to the start value in the next cycle, takes priority over a strobe in the same clock, and clears the half-rate phase.
- R6: Each frame-buffer access strobe decrements the 8-bit refresh counter by one, wrapping from 00 to FF.
- R7: While the sync output is low, the bus carries the refresh counter at bits [7:0] for modes 000, 101 and 11x, at [8:1] for 001, at [9:2] for 010, at [10:3] for 011 and at [11:4] for 100. All other bus bits and all four upper bits are 0.
- R8: While the start bit is clear, the sync output is held low whatever the sync input does, and display strobes do not move the address.
- R9: While the sync output is high, the bus carries address bits [15:0] and the upper output carries address bits [19:16].
- R10: Without a strobe or a load, the display address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_bit | input | 1 | Operation enable from the mode register |
| inc_mode | input | 3 | Address step-mode code |
| load_start | input | 1 | Load the start address |
| start_addr | input | 20 | Start address value |
| disp_strobe | input | 1 | One pulse per display cycle |
| fb_strobe | input | 1 | One pulse per frame-buffer access |
| hsync_n_in | input | 1 | Horizontal sync from the timing generator |
| hsync_n_out | output | 1 | Horizontal sync, held low until started |
| disp_addr | output | 20 | Current display address |
| bus_out | output | 16 | Multiplexed bus value (address or refresh) |
| bus_upper | output | 4 | Upper address bits, 0 during refresh |
| refresh_on | output | 1 | High while refresh is on the bus |

## Verification
The bench builds the block with its default parameters: a 20-bit address, an 8-bit refresh counter and a 16-bit bus with 4 upper bits. At these sizes the refresh counter wraps after 256 access strobes. A load near the top of the address space makes the 20-bit wrap visible after a single step. With a 16-bit bus and a counter 8 bits wide, the widest placement, at [11:4], still fits. This lets every mode's refresh position be seen on the bus, together with the cleared bits around it.

// File: rtl/gai_pkg.sv
// Shared definitions for the display-address stepper and refresh generator.
// Assumes the 3-bit step-mode encoding given in the brief.
package gai_pkg;

    typedef enum logic [2:0] {
        MODE_STEP1  = 3'b000,
        MODE_STEP2  = 3'b001,
        MODE_STEP4  = 3'b010,
        MODE_STEP8  = 3'b011,
        MODE_STEP16 = 3'b100,
        MODE_HOLD   = 3'b101,
        MODE_HALF_A = 3'b110,
        MODE_HALF_B = 3'b111
    } step_mode_e;

    // largest left shift used for a step size or a refresh placement
    localparam int unsigned MAX_SHIFT = 4;

    // true for the two half-rate codes
    function automatic logic is_half_rate(input logic [2:0] m);
        return m[2] & m[1];
    endfunction

    // true for the five fixed power-of-two step codes
    function automatic logic is_pow2_step(input logic [2:0] m);
        return (m <= 3'(MODE_STEP16));
    endfunction

    // shift used both for step size and refresh field position
    function automatic logic [2:0] mode_shift(input logic [2:0] m);
        return is_pow2_step(m) ? m : 3'd0;
    endfunction

endpackage

// File: rtl/gai_addr_step.sv
// Display address register with programmable stepping.
// Assumes: load has priority over a strobe; half-rate phase is kept here
// and cleared on load; stepping only while 'run' is high.
module gai_addr_step
    import gai_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2:0]        mode,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              strobe,
    output logic [ADDR_W-1:0] addr
);

    logic              half_phase;
    logic [ADDR_W-1:0] step_val;
    logic              do_step;

    // step amount for the current mode (0 when the mode does not advance)
    always_comb begin
        step_val = '0;
        do_step  = 1'b0;
        if (is_pow2_step(mode)) begin
            step_val = ADDR_W'(1) << mode_shift(mode);
            do_step  = 1'b1;
        end else if (is_half_rate(mode)) begin
            step_val = ADDR_W'(1);
            do_step  = half_phase;
        end
    end

    // address and half-rate phase registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr       <= '0;
            half_phase <= 1'b0;
        end else if (load) begin
            addr       <= load_val;
            half_phase <= 1'b0;
        end else if (run && strobe) begin
            if (do_step) begin
                addr <= addr + step_val;
            end
            if (is_half_rate(mode)) begin
                half_phase <= ~half_phase;
            end
        end
    end

endmodule

// File: rtl/gai_refresh_ctr.sv
// DRAM refresh row counter: counts down once per frame-buffer access and
// wraps through all ones. Assumes one access strobe per clock at most.
module gai_refresh_ctr #(
    parameter int REF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    output logic [REF_W-1:0] count
);

    // down counter, free running on access strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (access) begin
            count <= count - REF_W'(1);
        end
    end

endmodule

// File: rtl/gai_bus_mux.sv
// Selects what drives the multiplexed frame-buffer bus: the display address,
// or during refresh the refresh count shifted to the mode's field position
// with every other bit low. Assumes BUS_W >= REF_W + MAX_SHIFT and
// ADDR_W == BUS_W + UP_W.
module gai_bus_mux
    import gai_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BUS_W  = 16,
    parameter int UP_W   = 4,
    parameter int REF_W  = 8
) (
    input  logic              refresh,
    input  logic [2:0]        mode,
    input  logic [REF_W-1:0]  ref_count,
    input  logic [ADDR_W-1:0] addr,
    output logic [BUS_W-1:0]  bus,
    output logic [UP_W-1:0]   upper
);

    localparam int NPOS  = MAX_SHIFT + 1;
    localparam int PAD_W = BUS_W - REF_W;

    logic [BUS_W-1:0] placed [NPOS];
    logic [2:0]       pos_sel;

    // one candidate bus word per refresh field position
    for (genvar k = 0; k < NPOS; k++) begin : g_place
        assign placed[k] = {{PAD_W{1'b0}}, ref_count} << k;
    end

    // field position chosen by the step mode
    always_comb begin
        pos_sel = mode_shift(mode);
    end

    // bus source select
    always_comb begin
        if (refresh) begin
            bus   = placed[pos_sel];
            upper = '0;
        end else begin
            bus   = addr[BUS_W-1:0];
            upper = addr[ADDR_W-1 -: UP_W];
        end
    end

endmodule

// File: rtl/gai_refresh_unit.sv
// Top: display address stepping plus DRAM refresh output on the
// multiplexed frame-buffer bus. Sync output is forced low until the start
// bit is set, which keeps refresh on the bus and the address still.
module gai_refresh_unit
    import gai_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BUS_W  = 16,
    parameter int UP_W   = 4,
    parameter int REF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_bit,
    input  logic [2:0]        inc_mode,
    input  logic              load_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              disp_strobe,
    input  logic              fb_strobe,
    input  logic              hsync_n_in,
    output logic              hsync_n_out,
    output logic [ADDR_W-1:0] disp_addr,
    output logic [BUS_W-1:0]  bus_out,
    output logic [UP_W-1:0]   bus_upper,
    output logic              refresh_on
);

    logic [REF_W-1:0] ref_count;

    // sync gating: low until started, refresh whenever sync is low
    always_comb begin
        hsync_n_out = start_bit & hsync_n_in;
        refresh_on  = ~hsync_n_out;
    end

    gai_addr_step #(
        .ADDR_W (ADDR_W)
    ) i_addr_step (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (start_bit),
        .mode     (inc_mode),
        .load     (load_start),
        .load_val (start_addr),
        .strobe   (disp_strobe),
        .addr     (disp_addr)
    );

    gai_refresh_ctr #(
        .REF_W (REF_W)
    ) i_refresh_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access (fb_strobe),
        .count  (ref_count)
    );

    gai_bus_mux #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W),
        .UP_W   (UP_W),
        .REF_W  (REF_W)
    ) i_bus_mux (
        .refresh   (refresh_on),
        .mode      (inc_mode),
        .ref_count (ref_count),
        .addr      (disp_addr),
        .bus       (bus_out),
        .upper     (bus_upper)
    );

endmodule

// File: rtl/gai_refresh_chk.sv
// Checker for gai_refresh_unit, bound to every instance of it.
module gai_refresh_chk #(
    parameter int ADDR_W = 20,
    parameter int BUS_W  = 16,
    parameter int UP_W   = 4,
    parameter int REF_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_bit,
    input logic [2:0]        inc_mode,
    input logic              load_start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              disp_strobe,
    input logic              fb_strobe,
    input logic              hsync_n_out,
    input logic [ADDR_W-1:0] disp_addr,
    input logic [UP_W-1:0]   bus_upper,
    input logic              refresh_on,
    input logic [REF_W-1:0]  ref_count
);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_bit && disp_strobe && !load_start && inc_mode <= 3'b100)
        |=> disp_addr == $past(disp_addr) + (ADDR_W'(1) << $past(inc_mode)));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_strobe && !load_start && inc_mode == 3'b101) |=> $stable(disp_addr));

    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> disp_addr == $past(start_addr));

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fb_strobe |=> ref_count == $past(ref_count) - REF_W'(1));

    p_upper_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_on |-> bus_upper == '0);

    p_sync_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start_bit |-> !hsync_n_out);

    p_no_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_bit && !load_start) |=> $stable(disp_addr));

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_strobe && !load_start) |=> $stable(disp_addr));

endmodule

bind gai_refresh_unit gai_refresh_chk #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W),
    .UP_W   (UP_W),
    .REF_W  (REF_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_bit   (start_bit),
    .inc_mode    (inc_mode),
    .load_start  (load_start),
    .start_addr  (start_addr),
    .disp_strobe (disp_strobe),
    .fb_strobe   (fb_strobe),
    .hsync_n_out (hsync_n_out),
    .disp_addr   (disp_addr),
    .bus_upper   (bus_upper),
    .refresh_on  (refresh_on),
    .ref_count   (ref_count)
);

// File: tb/test_gai_refresh_unit.sv
module test_gai_refresh_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_bit;
    logic [2:0]  inc_mode;
    logic        load_start;
    logic [19:0] start_addr;
    logic        disp_strobe;
    logic        fb_strobe;
    logic        hsync_n_in;
    logic        hsync_n_out;
    logic [19:0] disp_addr;
    logic [15:0] bus_out;
    logic [3:0]  bus_upper;
    logic        refresh_on;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gai_refresh_unit i_gai_refresh_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_bit   (start_bit),
        .inc_mode    (inc_mode),
        .load_start  (load_start),
        .start_addr  (start_addr),
        .disp_strobe (disp_strobe),
        .fb_strobe   (fb_strobe),
        .hsync_n_in  (hsync_n_in),
        .hsync_n_out (hsync_n_out),
        .disp_addr   (disp_addr),
        .bus_out     (bus_out),
        .bus_upper   (bus_upper),
        .refresh_on  (refresh_on)
    );

    // {mode, start address, strobe count, expected address}
    localparam logic [46:0] VEC [0:9] = '{
        {3'b000, 20'h00010, 4'd3, 20'h00013},
        {3'b001, 20'h00100, 4'd2, 20'h00104},
        {3'b010, 20'h00200, 4'd3, 20'h0020C},
        {3'b011, 20'h00000, 4'd4, 20'h00020},
        {3'b100, 20'hFFFF0, 4'd1, 20'h00000},
        {3'b101, 20'h12345, 4'd5, 20'h12345},
        {3'b110, 20'h00050, 4'd1, 20'h00050},
        {3'b111, 20'h00050, 4'd3, 20'h00051},
        {3'b110, 20'h00050, 4'd4, 20'h00052},
        {3'b000, 20'hFFFFF, 4'd1, 20'h00000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [19:0] a);
        @(negedge clk);
        load_start = 1'b1;
        start_addr = a;
        @(negedge clk);
        load_start = 1'b0;
    endtask

    task automatic do_disp(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            disp_strobe = 1'b1;
            @(negedge clk);
            disp_strobe = 1'b0;
        end
    endtask

    task automatic do_access(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            fb_strobe = 1'b1;
            @(negedge clk);
            fb_strobe = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        start_bit   = 1'b0;
        inc_mode    = 3'b000;
        load_start  = 1'b0;
        start_addr  = '0;
        disp_strobe = 1'b0;
        fb_strobe   = 1'b0;
        hsync_n_in  = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R8 sync held low before start
        check("R1 addr", 32'(disp_addr), 32'h0);
        check("R1 sync", 32'(hsync_n_out), 32'h0);
        check("R1 bus refresh zero", 32'(bus_out), 32'h0);
        check("R8 refresh while stopped", 32'(refresh_on), 32'h1);

        // R6 countdown and R7 field placement per mode
        do_access(3);
        inc_mode = 3'b000; #1 check("R7 mode000 [7:0]", 32'(bus_out), 32'h00FD);
        inc_mode = 3'b001; #1 check("R7 mode001 [8:1]", 32'(bus_out), 32'h01FA);
        inc_mode = 3'b010; #1 check("R7 mode010 [9:2]", 32'(bus_out), 32'h03F4);
        inc_mode = 3'b011; #1 check("R7 mode011 [10:3]", 32'(bus_out), 32'h07E8);
        inc_mode = 3'b100; #1 check("R7 mode100 [11:4]", 32'(bus_out), 32'h0FD0);
        inc_mode = 3'b101; #1 check("R7 mode101 [7:0]", 32'(bus_out), 32'h00FD);
        inc_mode = 3'b111; #1 check("R7 mode111 [7:0]", 32'(bus_out), 32'h00FD);
        check("R7 upper low", 32'(bus_upper), 32'h0);
        do_access(253);
        check("R6 count reaches 00", 32'(bus_out), 32'h0000);
        do_access(1);
        check("R6 wrap to FF", 32'(bus_out), 32'h00FF);

        // R8: stopped, load works but strobes do not move address
        inc_mode = 3'b000;
        do_load(20'h00100);
        do_disp(2);
        check("R8 no step while stopped", 32'(disp_addr), 32'h00100);
        check("R8 sync ignores input", 32'(hsync_n_out), 32'h0);

        // R2 R3 R4 R5 R9: table walk with start bit set, sync high
        start_bit = 1'b1;
        for (int i = 0; i < 10; i++) begin
            inc_mode = VEC[i][46:44];
            do_load(VEC[i][43:24]);
            do_disp(int'(VEC[i][23:20]));
            check($sformatf("R2/R3/R4 vec %0d addr", i), 32'(disp_addr), 32'(VEC[i][19:0]));
            check($sformatf("R9 vec %0d bus", i), 32'(bus_out), 32'(VEC[i][15:0]));
        end

        // R9 upper bits visible when sync high
        do_load(20'hA5432);
        check("R9 upper", 32'(bus_upper), 32'hA);
        check("R9 bus", 32'(bus_out), 32'h5432);

        // R7 refresh when sync input low after start
        hsync_n_in = 1'b0;
        inc_mode   = 3'b001;
        #1;
        check("R7 refresh on", 32'(refresh_on), 32'h1);
        check("R7 bus placed", 32'(bus_out), 32'h01FE);
        check("R7 upper cleared", 32'(bus_upper), 32'h0);
        hsync_n_in = 1'b1;

        // R5 load beats a strobe in the same clock
        inc_mode = 3'b000;
        @(negedge clk);
        load_start  = 1'b1;
        disp_strobe = 1'b1;
        start_addr  = 20'h00777;
        @(negedge clk);
        load_start  = 1'b0;
        disp_strobe = 1'b0;
        check("R5 load priority", 32'(disp_addr), 32'h00777);

        // R5 load clears half-rate phase
        inc_mode = 3'b110;
        do_load(20'h00200);
        do_disp(1);
        do_load(20'h00300);
        do_disp(1);
        check("R5 phase cleared", 32'(disp_addr), 32'h00300);
        do_disp(1);
        check("R4 second strobe steps", 32'(disp_addr), 32'h00301);

        // R10 idle holds
        repeat (4) @(negedge clk);
        check("R10 idle hold", 32'(disp_addr), 32'h00301);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule